// File: doc/BRIEF.md
# Sample Strobe Divider with Capture Duration and Fill Status

This block produces the per-cycle sample-enable strobe that a logic capture engine uses to decide when to store a sample. It divides the 100 MHz reference down to a programmed rate by counting to a terminal value. It can also skip the divider and strobe on every cycle of whatever clock drives it. Skipping is for 125 MHz capture and for externally clocked capture. The divider setting and the skip choice are taken in when a capture starts.

While a capture runs, the block counts elapsed time in units of a fixed number of clock cycles. That is one millisecond at the 100 MHz reference. In skip mode the same count runs on the faster clock, so a unit is really 0.8 ms at 125 MHz. The block also tracks how many strobes have been written to capture memory since the trigger, against a threshold set a little below the memory depth. It raises a sticky triggered flag, a memory-available flag and a capturing flag, which a host polls. A stop command ends the run and drops skip mode. The counters keep their values so the host can read them afterwards.

Top module: `scd_sample_timer`

## Requirements
- R1: With skip mode off, the divider terminal count `div_max` is latched at start. The strobe `sample_en` first goes high `div_max` cycles after the start edge and then once every `div_max`+1 cycles. A `div_max` of 0 strobes on every cycle.
- R2: With skip mode on (latched from `cfg_bypass`=1 at start), `sample_en` is high on every cycle while the block runs.
- R3: Changes to `cfg_div_max` or `cfg_bypass` while running have no effect on `sample_en` until the next start.
- R4: `duration` resets to 0 on start. While running, it increments once every `TICKS_PER_UNIT` cycles, whether or not skip mode is on. It holds its value while stopped.
- R5: `fill_count` resets to 0 on start. It counts `sample_en` cycles that occur after the triggered flag is set, and it saturates at `MEM_DEPTH - FULL_MARGIN`.
- R6: `mem_avail` is low exactly when `fill_count` equals `MEM_DEPTH - FULL_MARGIN`. `capturing` is high only while the block runs and `mem_avail` is high.
- R7: `triggered` is set in the cycle after the first `trigger_hit` seen while running. It stays set until the next start. A `trigger_hit` while stopped has no effect.
- R8: `stop` ends the run and clears skip mode. `stop` wins over a simultaneous `start`. After a stop, `sample_en` and `capturing` are low, and `duration`, `fill_count` and `triggered` hold their values.
- R9: After reset, `sample_en`, `capturing`, `triggered`, `duration` and `fill_count` are 0 and `mem_avail` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock (100 MHz reference, or the fast/external clock in skip mode) |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a capture: latch configuration, clear counters and flags |
| stop | input | 1 | End a capture and clear skip mode |
| cfg_bypass | input | 1 | Skip-mode request, latched at start |
| cfg_div_max | input | DIV_W | Divider terminal count, latched at start |
| trigger_hit | input | 1 | Trigger condition met this cycle |
| sample_en | output | 1 | Sample strobe |
| fill_count | output | $clog2(MEM_DEPTH+1) | Samples stored since the trigger |
| duration | output | DUR_W | Elapsed capture time in units |
| triggered | output | 1 | Sticky trigger flag |
| mem_avail | output | 1 | Memory still below the full threshold |
| capturing | output | 1 | Run active and memory available |

## Verification
The bench builds the block with `TICKS_PER_UNIT`=20, `MEM_DEPTH`=64, `FULL_MARGIN`=16 and `DIV_W`=8. With these values the duration counter advances many times per run, and the 48-sample full threshold is reached within a few hundred cycles. Saturation, the falling memory-available flag and the loss of `capturing` are all exercised at these sizes. Random divider values from 0 to 5 mixed with skip mode cover both strobe variants and the every-cycle edge case. Random start/stop overlap covers the stop-wins ordering.

// File: rtl/scd_pkg.sv
// Shared types for the sample strobe divider.
// Assumes start and stop are single-cycle or level pulses sampled on clk.
package scd_pkg;
    // Run command decoded once from start/stop; stop has priority.
    typedef enum logic [1:0] {
        RC_HOLD  = 2'd0,
        RC_STOP  = 2'd1,
        RC_START = 2'd2
    } run_cmd_e;
endpackage

// File: rtl/scd_run_ctl.sv
// Run control: decodes start/stop and latches the divider configuration.
// Assumes configuration inputs are valid in the cycle start is high.
module scd_run_ctl
    import scd_pkg::*;
#(
    parameter int DIV_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             stop,
    input  logic             cfg_bypass,
    input  logic [DIV_W-1:0] cfg_div_max,
    output run_cmd_e         cmd,
    output logic             running,
    output logic             byp_q,
    output logic [DIV_W-1:0] div_q
);
    // Decode the command; stop wins over start.
    always_comb begin
        if (stop)       cmd = RC_STOP;
        else if (start) cmd = RC_START;
        else            cmd = RC_HOLD;
    end

    // Hold run state and the configuration taken at start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            running <= 1'b0;
            byp_q   <= 1'b0;
            div_q   <= '0;
        end else if (cmd == RC_STOP) begin
            running <= 1'b0;
            byp_q   <= 1'b0;
        end else if (cmd == RC_START) begin
            running <= 1'b1;
            byp_q   <= cfg_bypass;
            div_q   <= cfg_div_max;
        end
    end

    p_stop_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == RC_STOP) |=> (!running && !byp_q));
endmodule

// File: rtl/scd_divider.sv
// Strobe divider: one strobe per div_q+1 cycles, or every cycle when skipped.
// Assumes div_q and byp_q only change on a run command.
module scd_divider
    import scd_pkg::*;
#(
    parameter int DIV_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  run_cmd_e         cmd,
    input  logic             running,
    input  logic             byp_q,
    input  logic [DIV_W-1:0] div_q,
    output logic             sample_en
);
    logic [DIV_W-1:0] cnt;

    // Count toward the terminal value; restart on any command or in skip mode.
    always_ff @(posedge clk) begin
        if (!rst_n)                                  cnt <= '0;
        else if (cmd != RC_HOLD || !running || byp_q) cnt <= '0;
        else if (cnt == div_q)                       cnt <= '0;
        else                                         cnt <= cnt + 1'b1;
    end

    // Strobe at the terminal value, or always when skipped.
    assign sample_en = running && (byp_q || (cnt == div_q));

    p_gap_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (sample_en && !byp_q && div_q != '0 && cmd == RC_HOLD) |=> !sample_en);
endmodule

// File: rtl/scd_duration.sv
// Duration timer: one unit per TICKS_PER_UNIT cycles of the running clock.
// Assumes TICKS_PER_UNIT >= 2; the time base is not scaled in skip mode.
module scd_duration
    import scd_pkg::*;
#(
    parameter int TICKS_PER_UNIT = 100000,
    parameter int DUR_W          = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  run_cmd_e         cmd,
    input  logic             running,
    output logic [DUR_W-1:0] duration
);
    localparam int TICK_W = $clog2(TICKS_PER_UNIT);
    localparam logic [TICK_W-1:0] TICK_LAST = TICK_W'(TICKS_PER_UNIT - 1);

    logic [TICK_W-1:0] tick;

    // Advance the prescaler and bump the unit count on its wrap.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tick     <= '0;
            duration <= '0;
        end else if (cmd == RC_START) begin
            tick     <= '0;
            duration <= '0;
        end else if (cmd == RC_STOP) begin
            tick     <= '0;
        end else if (running) begin
            if (tick == TICK_LAST) begin
                tick     <= '0;
                duration <= duration + 1'b1;
            end else begin
                tick     <= tick + 1'b1;
            end
        end
    end

    p_dur_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == RC_HOLD) |=> (duration == $past(duration) ||
                              duration == DUR_W'($past(duration) + 1'b1)));
endmodule

// File: rtl/scd_fill.sv
// Fill tracker: sticky trigger flag and post-trigger sample count.
// Assumes the full threshold MEM_DEPTH - FULL_MARGIN is positive.
module scd_fill
    import scd_pkg::*;
#(
    parameter int MEM_DEPTH   = 1024,
    parameter int FULL_MARGIN = 16,
    parameter int FILL_W      = $clog2(MEM_DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  run_cmd_e          cmd,
    input  logic              running,
    input  logic              sample_en,
    input  logic              trigger_hit,
    output logic              triggered,
    output logic [FILL_W-1:0] fill_count,
    output logic              mem_avail
);
    localparam logic [FILL_W-1:0] FULL_LIMIT = FILL_W'(MEM_DEPTH - FULL_MARGIN);

    // Latch the trigger and count stored samples up to the threshold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            triggered  <= 1'b0;
            fill_count <= '0;
        end else if (cmd == RC_START) begin
            triggered  <= 1'b0;
            fill_count <= '0;
        end else if (cmd == RC_HOLD) begin
            if (running && trigger_hit)
                triggered <= 1'b1;
            if (sample_en && triggered && fill_count < FULL_LIMIT)
                fill_count <= fill_count + 1'b1;
        end
    end

    assign mem_avail = (fill_count != FULL_LIMIT);

    p_fill_cap_r5: assert property (@(posedge clk) disable iff (!rst_n)
        fill_count <= FULL_LIMIT);
    p_fill_pretrig_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!triggered && cmd == RC_HOLD) |=> (fill_count == $past(fill_count)));
    p_trig_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (triggered && cmd != RC_START) |=> triggered);
endmodule

// File: rtl/scd_sample_timer.sv
// Top: sample strobe divider, capture duration timer and fill status.
// Assumes clk is the reference, or the fast clock when skip mode is chosen.
module scd_sample_timer
    import scd_pkg::*;
#(
    parameter int DIV_W          = 32,
    parameter int DUR_W          = 32,
    parameter int TICKS_PER_UNIT = 100000,
    parameter int MEM_DEPTH      = 1024,
    parameter int FULL_MARGIN    = 16,
    localparam int FILL_W        = $clog2(MEM_DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              stop,
    input  logic              cfg_bypass,
    input  logic [DIV_W-1:0]  cfg_div_max,
    input  logic              trigger_hit,
    output logic              sample_en,
    output logic [FILL_W-1:0] fill_count,
    output logic [DUR_W-1:0]  duration,
    output logic              triggered,
    output logic              mem_avail,
    output logic              capturing
);
    run_cmd_e         cmd;
    logic             running;
    logic             byp_q;
    logic [DIV_W-1:0] div_q;

    scd_run_ctl #(.DIV_W(DIV_W)) u_ctl (
        .clk(clk), .rst_n(rst_n), .start(start), .stop(stop),
        .cfg_bypass(cfg_bypass), .cfg_div_max(cfg_div_max),
        .cmd(cmd), .running(running), .byp_q(byp_q), .div_q(div_q)
    );

    scd_divider #(.DIV_W(DIV_W)) u_div (
        .clk(clk), .rst_n(rst_n), .cmd(cmd), .running(running),
        .byp_q(byp_q), .div_q(div_q), .sample_en(sample_en)
    );

    scd_duration #(.TICKS_PER_UNIT(TICKS_PER_UNIT), .DUR_W(DUR_W)) u_dur (
        .clk(clk), .rst_n(rst_n), .cmd(cmd), .running(running),
        .duration(duration)
    );

    scd_fill #(.MEM_DEPTH(MEM_DEPTH), .FULL_MARGIN(FULL_MARGIN), .FILL_W(FILL_W)) u_fill (
        .clk(clk), .rst_n(rst_n), .cmd(cmd), .running(running),
        .sample_en(sample_en), .trigger_hit(trigger_hit),
        .triggered(triggered), .fill_count(fill_count), .mem_avail(mem_avail)
    );

    // Capture is live while running and memory remains.
    assign capturing = running && mem_avail;

    p_skip_strobe_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(cmd) == RC_START && $past(cfg_bypass) && cmd == RC_HOLD) |-> sample_en);
    p_stop_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        stop |=> (!sample_en && !capturing));
endmodule

// File: tb/tb_scd_sample_timer.sv
module tb_scd_sample_timer;
    localparam int CLK_PERIOD = 10;
    localparam int DIV_W = 8;
    localparam int DUR_W = 16;
    localparam int TPU   = 20;
    localparam int DEPTH = 64;
    localparam int MARG  = 16;
    localparam int LIM   = DEPTH - MARG;
    localparam int FW    = $clog2(DEPTH + 1);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0, stop = 1'b0, cfg_bypass = 1'b0, trigger_hit = 1'b0;
    logic [DIV_W-1:0] cfg_div_max = '0;
    logic sample_en, triggered, mem_avail, capturing;
    logic [FW-1:0] fill_count;
    logic [DUR_W-1:0] duration;

    int n_run = 0, n_fail = 0;
    bit armed = 0, done = 0;

    // Reference model state
    bit m_run, m_byp, m_trig;
    int m_div, m_cnt, m_tick, m_dur, m_fill;

    always #(CLK_PERIOD/2) clk = ~clk;

    scd_sample_timer #(.DIV_W(DIV_W), .DUR_W(DUR_W), .TICKS_PER_UNIT(TPU),
                       .MEM_DEPTH(DEPTH), .FULL_MARGIN(MARG)) dut (
        .clk(clk), .rst_n(rst_n), .start(start), .stop(stop),
        .cfg_bypass(cfg_bypass), .cfg_div_max(cfg_div_max),
        .trigger_hit(trigger_hit), .sample_en(sample_en),
        .fill_count(fill_count), .duration(duration), .triggered(triggered),
        .mem_avail(mem_avail), .capturing(capturing));

    function automatic bit exp_sen();
        return m_run && (m_byp || m_cnt == m_div);
    endfunction

    task automatic chk(input string tag, input longint act, input longint exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // Model update at the active edge, from the requirements.
    always @(posedge clk) begin
        armed <= 1'b1;
        if (!rst_n) begin
            m_run <= 0; m_byp <= 0; m_trig <= 0; m_div <= 0;
            m_cnt <= 0; m_tick <= 0; m_dur <= 0; m_fill <= 0;
        end else if (stop) begin
            m_run <= 0; m_byp <= 0; m_cnt <= 0; m_tick <= 0;
        end else if (start) begin
            m_run <= 1; m_byp <= cfg_bypass; m_div <= int'(cfg_div_max);
            m_cnt <= 0; m_tick <= 0; m_dur <= 0; m_fill <= 0; m_trig <= 0;
        end else if (m_run) begin
            m_cnt <= (m_byp || m_cnt == m_div) ? 0 : m_cnt + 1;
            if (m_tick == TPU - 1) begin
                m_tick <= 0; m_dur <= (m_dur + 1) % (1 << DUR_W);
            end else m_tick <= m_tick + 1;
            if (trigger_hit) m_trig <= 1;
            if (exp_sen() && m_trig && m_fill < LIM) m_fill <= m_fill + 1;
        end
    end

    // Per-cycle comparison away from the active edge.
    always @(negedge clk) begin
        if (armed && rst_n && !done) begin
            chk(m_byp ? "R2 sample_en" : "R1 sample_en", sample_en, exp_sen());
            chk("R4 duration", duration, m_dur);
            chk("R5 fill_count", fill_count, m_fill);
            chk("R6 mem_avail", mem_avail, m_fill != LIM);
            chk("R6 capturing", capturing, m_run && m_fill != LIM);
            chk("R7 triggered", triggered, m_trig);
        end
    end

    task automatic cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic do_start(input bit byp, input int div);
        cfg_bypass = byp; cfg_div_max = DIV_W'(div); start = 1;
        @(negedge clk); start = 0;
    endtask

    task automatic do_stop();
        stop = 1; @(negedge clk); stop = 0;
    endtask

    initial begin : watchdog
        #(CLK_PERIOD * 200000);
        if (!done) begin
            done = 1; n_fail++; n_run++;
            $display("FAIL watchdog expired");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin : stim
        int cnt;
        void'($urandom(32'h5EED_1234));
        cyc(3);
        // R9 reset state
        chk("R9 sample_en", sample_en, 0);
        chk("R9 capturing", capturing, 0);
        chk("R9 triggered", triggered, 0);
        chk("R9 duration", duration, 0);
        chk("R9 fill_count", fill_count, 0);
        chk("R9 mem_avail", mem_avail, 1);
        rst_n = 1; cyc(2);

        // R7 trigger while idle is ignored
        trigger_hit = 1; cyc(2); trigger_hit = 0;
        chk("R7 idle trigger ignored", triggered, 0);

        // R1 div 0 every cycle, R5/R6 fill to threshold after trigger
        do_start(0, 0);
        cyc(10);
        chk("R5 no fill before trigger", fill_count, 0);
        trigger_hit = 1; @(negedge clk); trigger_hit = 0;
        cyc(LIM + 10);
        chk("R5 saturated fill", fill_count, LIM);
        chk("R6 mem_avail low at full", mem_avail, 0);
        chk("R6 capturing low at full", capturing, 0);
        do_stop();
        chk("R8 sample_en after stop", sample_en, 0);
        chk("R8 fill held after stop", fill_count, LIM);
        chk("R8 triggered held after stop", triggered, 1);
        cyc(5);

        // R3 config changes mid-run ignored; div 3 gives strobe every 4 cycles
        do_start(0, 3);
        cnt = 0;
        for (int i = 0; i < 40; i++) begin
            cnt += int'(sample_en);
            if (i == 2) begin cfg_div_max = '0; cfg_bypass = 1; end
            @(negedge clk);
        end
        chk("R3 strobes in 40 cycles", cnt, 10);
        do_stop();

        // R2 skip mode every cycle
        do_start(1, 5);
        cnt = 0;
        for (int i = 0; i < 30; i++) begin cnt += int'(sample_en); @(negedge clk); end
        chk("R2 skip strobes in 30 cycles", cnt, 30);

        // R8 stop wins over start
        start = 1; stop = 1; @(negedge clk); start = 0; stop = 0;
        chk("R8 stop wins sample_en", sample_en, 0);
        chk("R8 stop wins capturing", capturing, 0);
        cyc(4);

        // Random sessions
        for (int s = 0; s < 40; s++) begin
            do_start(1'($urandom_range(0, 1)), int'($urandom_range(0, 5)));
            for (int c = 0; c < 150; c++) begin
                trigger_hit = ($urandom_range(0, 15) == 0);
                cfg_div_max = DIV_W'($urandom_range(0, 7));
                cfg_bypass  = 1'($urandom_range(0, 1));
                start = ($urandom_range(0, 99) == 0);
                stop  = ($urandom_range(0, 99) == 0);
                @(negedge clk);
            end
            start = 0; stop = 0; trigger_hit = 0;
            do_stop();
            cyc(3);
        end

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule